// File: doc/BRIEF.md
# Streaming Byte Writer for Parallel Non-Volatile Memory

This block takes bytes that arrive one at a time, each marked by a single-cycle valid strobe, and stores them in order into an external byte-wide asynchronous non-volatile memory. Each accepted byte starts a self-timed write cycle with three parts: address and data setup, then a low pulse on chip enable and write enable, then a data hold. After the hold, the internal address pointer steps to the next location. The first write goes to address zero.

The sender is not paced by the block. A `busy` output shows when a write cycle is in progress. A byte that arrives while `busy` is high is thrown away, and a sticky overrun flag records that it happened. When the write to the highest address finishes, a sticky full flag is set and every later byte is ignored. Output enable is never asserted. The data pad is driven only while a write cycle is in progress, using a separate drive-enable signal, so the pad cell can sit outside the block. The setup, pulse and hold lengths are parameters, and so are the address and data widths. By default the address is 23 bits and the data is 8 bits, which covers 64 Mbit.

Top module: `pmem_byte_writer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears its state. After that edge, `mem_addr` is 0, `mem_ce_n` and `mem_we_n` are 1, `mem_dq_oe`, `busy`, `overrun` and `full` are 0.
- R2: A byte is accepted when `in_valid` is 1 at a clock edge while `busy` is 0 and `full` is 0. The accepted byte is written to the current value of `mem_addr`.
- R3: A write cycle has three parts, in this order. First come SETUP_CYC cycles with `mem_ce_n` and `mem_we_n` both 1. Next come PULSE_CYC cycles with `mem_ce_n` and `mem_we_n` both 0. Last come HOLD_CYC cycles with both strobes back at 1.
- R4: `mem_oe_n` is 1 in every cycle.
- R5: `mem_dq_oe` is 1 in exactly the cycles in which a write cycle is in progress. During that time `mem_dq_o` carries the accepted byte and does not change.
- R6: `mem_addr` stays unchanged for the whole write cycle. At the edge that ends the hold part, it increases by exactly one. Bytes therefore land at consecutive addresses in the order they arrive.
- R7: `busy` is 1 for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC cycles, starting with the cycle after the accepting edge.
- R8: If `in_valid` is 1 at an edge while `busy` is 1, that byte is dropped and never written, and `overrun` becomes 1.
- R9: When the write to address 2^ADDR_W−1 finishes, `full` becomes 1 and `mem_addr` stays at that address. After that, a valid byte starts no write cycle and does not set `overrun`.
- R10: Once set, `overrun` and `full` stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Byte strobe, one cycle per byte |
| in_byte | input | DATA_W | Incoming byte |
| busy | output | 1 | Write cycle in progress |
| overrun | output | 1 | Sticky flag: a byte arrived while busy |
| full | output | 1 | Sticky flag: the last address has been written |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_dq_o | output | DATA_W | Write data toward the data pad |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low, held inactive |

## Verification
The bench sends bytes on the last cycle of `busy`, where a design that is off by one cycle in its busy window would either accept the byte or flag an overrun wrongly. It also sends them on the cycle right after `busy` falls, and back to back, which exposes an overrun flag that is not sticky or a dropped byte that still gets written. It fills a small memory up to its top address, then keeps sending. A design that wraps the pointer would overwrite address 0, and one that lets the full state through would start new strobe pulses. Every write is captured on the rising edge of write enable and compared with the arrival order, which catches data that changes mid-cycle or a pointer that steps before the hold part ends.

// File: rtl/pmem_pkg.sv
// Package: shared types and helpers for the parallel memory byte writer.
// Assumes: all users import it before declaring ports that use its types.
package pmem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } wr_phase_e;

    // Largest of three phase lengths, used to size the phase timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pmem_wr_seq.sv
// Module: write-cycle sequencer. On start it steps through the setup, pulse
// and hold phases, each for a fixed number of clocks, then goes back to idle.
// Assumes: every phase length is at least 1; start is only raised in idle.
module pmem_wr_seq
    import pmem_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output wr_phase_e phase,
    output logic      done
);
    localparam int MAXC = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);

    wr_phase_e     phase_q;
    logic [CW-1:0] left_q;
    logic          phase_end;

    assign phase_end = (left_q == '0);
    assign phase     = phase_q;
    assign done      = (phase_q == PH_HOLD) && phase_end;

    // Phase register and remaining-cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_SETUP;
                    left_q  <= LD_SETUP;
                end
                PH_SETUP: if (phase_end) begin
                    phase_q <= PH_PULSE;
                    left_q  <= LD_PULSE;
                end else begin
                    left_q <= left_q - 1'b1;
                end
                PH_PULSE: if (phase_end) begin
                    phase_q <= PH_HOLD;
                    left_q  <= LD_HOLD;
                end else begin
                    left_q <= left_q - 1'b1;
                end
                PH_HOLD: if (phase_end) begin
                    phase_q <= PH_IDLE;
                end else begin
                    left_q <= left_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pmem_addr_ctr.sv
// Module: byte address pointer with a sticky full flag. It steps once per
// finished write and stays at the top address once that address is written.
// Assumes: step is a one-cycle pulse at the end of each write cycle.
module pmem_addr_ctr #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              full
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    // Advance the pointer, or mark the memory full at the top address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            full <= 1'b0;
        end else if (step) begin
            if (addr == TOP) full <= 1'b1;
            else             addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/pmem_byte_writer.sv
// Module: top of the streaming byte writer. It accepts bytes while idle,
// latches each one, runs a timed write cycle on the memory strobes and keeps
// the overrun flag. Output enable is tied inactive.
// Assumes: in_valid is a one-cycle strobe per byte; the pad cell outside
// the block applies mem_dq_oe.
module pmem_byte_writer
    import pmem_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    output logic              busy,
    output logic              overrun,
    output logic              full,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    wr_phase_e         phase;
    logic              done;
    logic              accept;
    logic [DATA_W-1:0] data_q;
    logic              ovr_q;

    assign busy   = (phase != PH_IDLE);
    assign accept = in_valid && !busy && !full;

    pmem_wr_seq #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .phase(phase),
        .done (done)
    );

    pmem_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (done),
        .addr (mem_addr),
        .full (full)
    );

    // Latch the accepted byte for the whole write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= in_byte;
    end

    // Sticky overrun: a byte arrived while a write was in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr_q <= 1'b0;
        else if (in_valid && busy) ovr_q <= 1'b1;
    end

    // Strobe and pad-enable decode from the current phase.
    always_comb begin
        mem_ce_n  = (phase != PH_PULSE);
        mem_we_n  = (phase != PH_PULSE);
        mem_dq_oe = busy;
        mem_oe_n  = 1'b1;
    end

    assign mem_dq_o = data_q;
    assign overrun  = ovr_q;

endmodule

// File: rtl/pmem_byte_writer_chk.sv
// Module: assertion checker for pmem_byte_writer, attached with bind below.
// Assumes: it observes the top-level ports only.
module pmem_byte_writer_chk #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              busy,
    input logic              overrun,
    input logic              full,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n
);
    a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (mem_oe_n && mem_dq_oe));

    a_r5_dq_steady: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |=> (!mem_dq_oe || $stable(mem_dq_o)));

    a_r6_addr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_addr == $past(mem_addr) ||
                  mem_addr == $past(mem_addr) + 1'b1));

    a_r6_addr_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(mem_addr));

    a_r9_full_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !busy) |=> !busy);

    a_r10_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);

    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r8_ovr_on_busy_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy) |=> overrun);
endmodule

bind pmem_byte_writer pmem_byte_writer_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .busy     (busy),
    .overrun  (overrun),
    .full     (full),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n)
);

// File: tb/pmem_byte_writer_test.sv
// Bench: a behavioural reference model that is compared with the design on
// every clock, plus a write-capture memory that checks arrival order.
module pmem_byte_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int S  = 2;
    localparam int P  = 3;
    localparam int H  = 1;
    localparam int T  = S + P + H;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_byte = '0;
    logic          busy, overrun, full, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit finished = 0;

    // Reference model state
    int m_rem = 0;
    int m_addr = 0;
    int m_data = 0;
    bit m_ovr = 0;
    bit m_full = 0;
    int exp_mem [DEPTH];
    bit exp_wr [DEPTH];
    int got_mem [DEPTH];
    bit got_wr [DEPTH];
    logic prev_we = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmem_byte_writer #(
        .ADDR_W(AW), .DATA_W(DW),
        .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .busy(busy), .overrun(overrun), .full(full), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t",
                     req, what, act, exp, $time);
        end
    endtask

    // Reference model, one step per rising edge (R1, R2, R6, R7, R8, R9).
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_rem = 0; m_addr = 0; m_data = 0; m_ovr = 0; m_full = 0;
            foreach (exp_wr[i]) exp_wr[i] = 0;
            foreach (got_wr[i]) got_wr[i] = 0;
        end else if (m_rem == 0) begin
            if (in_valid && !m_full) begin
                m_rem = T;
                m_data = int'(in_byte);
                exp_mem[m_addr] = int'(in_byte);
                exp_wr[m_addr] = 1;
            end
        end else begin
            if (in_valid) m_ovr = 1;
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
                if (m_addr == DEPTH - 1) m_full = 1;
                else m_addr = m_addr + 1;
            end
        end
    end

    // Compare the outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            int e;
            bit m_busy, m_low;
            m_busy = (m_rem > 0);
            e = T - m_rem;
            m_low = m_busy && (e >= S) && (e < S + P);
            chk("R1/R6", "mem_addr", int'(mem_addr), m_addr);
            chk("R7", "busy", int'(busy), int'(m_busy));
            chk("R3", "mem_ce_n", int'(mem_ce_n), int'(!m_low));
            chk("R3", "mem_we_n", int'(mem_we_n), int'(!m_low));
            chk("R4", "mem_oe_n", int'(mem_oe_n), 1);
            chk("R5", "mem_dq_oe", int'(mem_dq_oe), int'(m_busy));
            if (m_busy) chk("R5", "mem_dq_o", int'(mem_dq_o), m_data);
            chk("R8/R10", "overrun", int'(overrun), int'(m_ovr));
            chk("R9/R10", "full", int'(full), int'(m_full));
            // capture a write on the rising edge of write enable
            if (prev_we === 1'b0 && mem_we_n === 1'b1) begin
                got_mem[mem_addr] = int'(mem_dq_o);
                got_wr[mem_addr] = 1;
            end
            prev_we = mem_we_n;
        end
    end

    task automatic send(input logic [DW-1:0] b, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check_memory(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            chk(tag, "written flag", int'(got_wr[i]), int'(exp_wr[i]));
            if (exp_wr[i]) chk(tag, "stored byte", got_mem[i], exp_mem[i]);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R5 R6 R7: single bytes with ample gaps
        send(8'hA5, T + 2);
        send(8'h3C, T + 1);
        // R7: next byte on the first idle cycle
        send(8'h7E, T - 1);
        send(8'h81, T);
        // R8: byte on the last busy cycle is dropped
        send(8'h11, T - 2);
        send(8'hEE, T + 2);
        // R8: back-to-back bytes
        send(8'h22, 0);
        send(8'h33, 0);
        send(8'h44, T + 3);
        // R9: fill up to the top address, then keep sending
        for (int k = 0; k < DEPTH; k++) send(8'(8'h50 + k), T);
        send(8'hF0, 2);
        send(8'hF1, T + 2);
        check_memory("R6/R9");
        // R10: flags clear only with reset; writing restarts at 0
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        send(8'hC3, T + 2);
        check_memory("R2/R6");
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule